// File: doc/BRIEF.md
# Sixteen-Element Permutation Ranking Unit

This unit turns an arrangement of the sixteen values 0..15 (for example a sliding-tile board with 0 as the empty cell) into a compact identifier. The arrangement arrives as one 64-bit word of sixteen 4-bit slots. In the main mode each slot value is lowered by the count of smaller values already seen in earlier slots. The lowered digits are then weighted in a falling-factorial number system. The outcome is a dense, one-to-one index below 16! that fits in 45 bits.

Two cheaper encodings can be selected instead. One is an inverse table where each value's slot holds the position at which that value occurs. The other keeps the first fifteen slots verbatim in 60 bits, since the last slot is implied by the other fifteen. The unit walks one slot per clock. It raises an error when a value appears twice, and it holds its outcome until the next request.

Top module: `perm_rank`

## Requirements
- R1: After reset, done_o, error_o and result_o are all 0.
- R2: When start_i is sampled high at a rising edge, done_o is low during the following 15 edges and goes high at the 16th rising edge after that one.
- R3: In mode 0 and mode 3, result_o holds the sum over k of d_k times the product of (16-j) for j<k, zero-extended from 45 bits. Slot k of state_i sits at bits [4k+3:4k]. d_k is the slot-k value minus the number of smaller values found in slots 0..k-1.
- R4: The identity arrangement (slot k holds k) ranks 0, and the reversed arrangement (slot k holds 15-k) ranks 16!-1 = 20922789887999.
- R5: In mode 1, bits [4v+3:4v] of result_o hold the slot index at which value v occurs.
- R6: In mode 2, result_o[59:0] equals state_i[59:0] and result_o[63:60] is 0.
- R7: If any value occurs more than once, error_o is 1 and result_o is 0 when done_o rises, in every mode.
- R8: state_i and mode_i are captured at start. Changes to them while the unit is working, or after done_o, do not alter result_o or error_o, which hold until the next start.
- R9: A start that arrives while the unit is working, or in the same cycle as done_o, drops done_o at the next edge and restarts the work on the newly captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new encoding; captures state_i and mode_i |
| mode_i | input | 2 | 0/3 rank, 1 inverse-position table, 2 truncated 60-bit copy |
| state_i | input | 64 | Sixteen 4-bit slots, slot k at bits [4k+3:4k] |
| done_o | output | 1 | Outcome valid, held until next start |
| error_o | output | 1 | Repeated value detected |
| result_o | output | 64 | Encoded outcome |

## Verification
The two events that can coincide are a fresh start and the completion of the running job. A new start can land in the very cycle where the last slot is folded in and done would rise. It can also land a few cycles into a running job. The bench provokes both. It issues a second start mid-run, and again while done_o is high. It then judges that done_o drops at the next edge, stays low for 15 more edges, and rises with the outcome of the second operand alone.

// File: rtl/perm_rank_pkg.sv
package perm_rank_pkg;
  typedef enum logic [1:0] {
    MODE_RANK  = 2'd0,
    MODE_POS   = 2'd1,
    MODE_TRUNC = 2'd2,
    MODE_RANK3 = 2'd3
  } mode_e;
endpackage

// File: rtl/perm_rank_ctrl.sv
module perm_rank_ctrl #(
  parameter int N_ELEM = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  output logic                        step_o,
  output logic                        last_o,
  output logic [$clog2(N_ELEM)-1:0]   idx_o
);
  localparam int EW = $clog2(N_ELEM);

  logic          busy_q;
  logic [EW-1:0] idx_q;

  assign last_o = (idx_q == EW'(N_ELEM - 1));
  assign step_o = busy_q && !start_i;
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + EW'(1);
    end
  end
endmodule

// File: rtl/perm_digit.sv
module perm_digit #(
  parameter int N_ELEM = 16
) (
  input  logic [$clog2(N_ELEM)-1:0] value_i,
  input  logic [N_ELEM-1:0]         used_i,
  output logic [$clog2(N_ELEM)-1:0] digit_o,
  output logic                      dup_o
);
  localparam int EW = $clog2(N_ELEM);

  logic [N_ELEM-1:0] below;
  logic [EW-1:0]     smaller;

  for (genvar g = 0; g < N_ELEM; g++) begin : g_below
    assign below[g] = used_i[g] && (EW'(g) < value_i);
  end

  always_comb begin
    smaller = '0;
    for (int i = 0; i < N_ELEM; i++)
      if (below[i]) smaller = smaller + EW'(1);
  end

  assign digit_o = value_i - smaller;
  assign dup_o   = used_i[value_i];
endmodule

// File: rtl/perm_accum.sv
module perm_accum #(
  parameter int N_ELEM = 16,
  parameter int RANK_W = 45
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               clear_i,
  input  logic                               step_i,
  input  logic [$clog2(N_ELEM)-1:0]          idx_i,
  input  logic [$clog2(N_ELEM)-1:0]          value_i,
  input  logic [$clog2(N_ELEM)-1:0]          digit_i,
  input  logic                               dup_i,
  output logic [N_ELEM-1:0]                  used_o,
  output logic [RANK_W-1:0]                  rank_nxt_o,
  output logic [N_ELEM*$clog2(N_ELEM)-1:0]   pos_nxt_o,
  output logic                               err_nxt_o
);
  localparam int EW     = $clog2(N_ELEM);
  localparam int WORD_W = N_ELEM * EW;

  logic [N_ELEM-1:0] used_q;
  logic [RANK_W-1:0] rank_q, weight_q, weight_nxt;
  logic [WORD_W-1:0] pos_q;
  logic              err_q;

  always_comb begin
    rank_nxt_o = rank_q + RANK_W'(digit_i) * weight_q;
    weight_nxt = weight_q * (RANK_W'(N_ELEM) - RANK_W'(idx_i));
    pos_nxt_o  = pos_q;
    pos_nxt_o[int'(value_i)*EW +: EW] = idx_i;
    err_nxt_o  = err_q | dup_i;
  end

  assign used_o = used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q   <= '0;
      rank_q   <= '0;
      weight_q <= RANK_W'(1);
      pos_q    <= '0;
      err_q    <= 1'b0;
    end else if (clear_i) begin
      used_q   <= '0;
      rank_q   <= '0;
      weight_q <= RANK_W'(1);
      pos_q    <= '0;
      err_q    <= 1'b0;
    end else if (step_i) begin
      used_q   <= used_q | (N_ELEM'(1) << value_i);
      rank_q   <= rank_nxt_o;
      weight_q <= weight_nxt;
      pos_q    <= pos_nxt_o;
      err_q    <= err_nxt_o;
    end
  end
endmodule

// File: rtl/perm_rank.sv
module perm_rank
  import perm_rank_pkg::*;
#(
  parameter int N_ELEM = 16,
  parameter int RANK_W = 45
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [1:0]                       mode_i,
  input  logic [N_ELEM*$clog2(N_ELEM)-1:0] state_i,
  output logic                             done_o,
  output logic                             error_o,
  output logic [N_ELEM*$clog2(N_ELEM)-1:0] result_o
);
  localparam int EW     = $clog2(N_ELEM);
  localparam int WORD_W = N_ELEM * EW;

  logic [WORD_W-1:0] state_q;
  mode_e             mode_q;
  logic              step, last;
  logic [EW-1:0]     idx, value, digit;
  logic              dup;
  logic [N_ELEM-1:0] used;
  logic [RANK_W-1:0] rank_nxt;
  logic [WORD_W-1:0] pos_nxt, sel;
  logic              err_nxt;

  perm_rank_ctrl #(.N_ELEM(N_ELEM)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .step_o(step), .last_o(last), .idx_o(idx)
  );

  assign value = state_q[int'(idx)*EW +: EW];

  perm_digit #(.N_ELEM(N_ELEM)) u_digit (
    .value_i(value), .used_i(used), .digit_o(digit), .dup_o(dup)
  );

  perm_accum #(.N_ELEM(N_ELEM), .RANK_W(RANK_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i), .step_i(step),
    .idx_i(idx), .value_i(value), .digit_i(digit), .dup_i(dup),
    .used_o(used), .rank_nxt_o(rank_nxt), .pos_nxt_o(pos_nxt),
    .err_nxt_o(err_nxt)
  );

  always_comb begin
    unique case (mode_q)
      MODE_POS:   sel = pos_nxt;
      MODE_TRUNC: sel = {{EW{1'b0}}, state_q[WORD_W-EW-1:0]};
      default:    sel = WORD_W'(rank_nxt);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      mode_q  <= MODE_RANK;
    end else if (start_i) begin
      state_q <= state_i;
      mode_q  <= mode_e'(mode_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      error_o  <= 1'b0;
      result_o <= '0;
    end else if (start_i) begin
      done_o   <= 1'b0;
      error_o  <= 1'b0;
      result_o <= '0;
    end else if (step && last) begin
      done_o   <= 1'b1;
      error_o  <= err_nxt;
      result_o <= err_nxt ? '0 : sel;
    end
  end
endmodule

// File: rtl/perm_rank_chk.sv
module perm_rank_chk #(
  parameter int N_ELEM = 16
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             start_i,
  input logic [1:0]                       mode_i,
  input logic                             done_o,
  input logic                             error_o,
  input logic [N_ELEM*$clog2(N_ELEM)-1:0] result_o
);
  localparam int EW     = $clog2(N_ELEM);
  localparam int WORD_W = N_ELEM * EW;
  localparam int CW     = $clog2(N_ELEM + 2) + 1;

  function automatic logic [WORD_W-1:0] fact_f();
    logic [WORD_W-1:0] f = WORD_W'(1);
    for (int i = 2; i <= N_ELEM; i++) f = f * WORD_W'(i);
    return f;
  endfunction
  localparam logic [WORD_W-1:0] FACT = fact_f();

  logic [CW-1:0] cyc_q;
  logic [1:0]    mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '1;
      mode_q <= '0;
    end else if (start_i) begin
      cyc_q  <= '0;
      mode_q <= mode_i;
    end else if (cyc_q != '1) begin
      cyc_q  <= cyc_q + CW'(1);
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cyc_q == CW'(N_ELEM));

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(result_o) && $stable(error_o)));

  p_err_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> result_o == '0);

  p_rank_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o && (mode_q == 2'd0 || mode_q == 2'd3)) |-> result_o < FACT);

  p_trunc_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == 2'd2) |-> result_o[WORD_W-1 -: EW] == '0);
endmodule

bind perm_rank perm_rank_chk #(.N_ELEM(N_ELEM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .done_o(done_o), .error_o(error_o), .result_o(result_o)
);

// File: tb/perm_rank_tb_top.sv
module perm_rank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [63:0] state = '0;
  logic        done, err;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_rank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .state_i(state), .done_o(done), .error_o(err), .result_o(result)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit has_dup(input logic [63:0] s);
    logic [15:0] seen = '0;
    for (int k = 0; k < 16; k++) begin
      if (seen[s[4*k +: 4]]) return 1'b1;
      seen[s[4*k +: 4]] = 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [63:0] ref_out(input logic [63:0] s, input logic [1:0] m);
    logic [63:0] acc = '0, w = 64'd1, pos = '0;
    logic [15:0] seen = '0;
    if (has_dup(s)) return '0;
    if (m == 2'd2) return {4'h0, s[59:0]};
    for (int k = 0; k < 16; k++) begin
      int v = int'(s[4*k +: 4]);
      int c = 0;
      for (int j = 0; j < v; j++) if (seen[j]) c++;
      acc = acc + 64'(v - c) * w;
      w   = w * 64'(16 - k);
      seen[v] = 1'b1;
      pos[4*v +: 4] = 4'(k);
    end
    return (m == 2'd1) ? pos : acc;
  endfunction

  function automatic logic [63:0] rand_perm();
    logic [3:0] a [16];
    logic [63:0] s;
    for (int i = 0; i < 16; i++) a[i] = 4'(i);
    for (int i = 15; i > 0; i--) begin
      int j = int'($urandom_range(i, 0));
      logic [3:0] t = a[i];
      a[i] = a[j];
      a[j] = t;
    end
    for (int i = 0; i < 16; i++) s[4*i +: 4] = a[i];
    return s;
  endfunction

  // start pulse, check R2 timing, then compare result; scramble exercises R8
  task automatic run_op(input logic [63:0] s, input logic [1:0] m, input bit scramble, input string tag);
    logic [63:0] exp = ref_out(s, m);
    @(negedge clk);
    state = s; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 15; i++) begin
      if (scramble) begin
        state = {$urandom, $urandom};
        mode  = 2'($urandom);
      end
      @(negedge clk);
    end
    check(done == 1'b0, "R2 done early", 64'(done), 64'd0);
    @(negedge clk);
    check(done == 1'b1, "R2 done late", 64'(done), 64'd1);
    check(err == has_dup(s), {tag, " error flag"}, 64'(err), 64'(has_dup(s)));
    check(result == exp, tag, result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] ident, rev, s, held, s2;
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 16; k++) begin
      ident[4*k +: 4] = 4'(k);
      rev[4*k +: 4]   = 4'(15 - k);
    end
    repeat (3) @(negedge clk);
    check(done == 1'b0 && err == 1'b0 && result == '0, "R1 reset state", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && result == '0, "R1 after release", result, 64'd0);

    run_op(ident, 2'd0, 1'b0, "R4 identity rank");
    check(result == 64'd0, "R4 identity is zero", result, 64'd0);
    run_op(rev, 2'd0, 1'b0, "R4 reversed rank");
    check(result == 64'd20922789887999, "R4 reversed is max", result, 64'd20922789887999);
    run_op(rev, 2'd3, 1'b0, "R3 mode3 reversed");
    run_op(ident, 2'd1, 1'b0, "R5 identity positions");
    run_op(rev, 2'd2, 1'b0, "R6 reversed truncated");

    for (int n = 0; n < 40; n++) begin
      s = rand_perm();
      run_op(s, 2'd0, 1'b0, "R3 random rank");
      run_op(s, 2'd1, 1'b0, "R5 random positions");
      run_op(s, 2'd2, 1'b0, "R6 random truncated");
      if (n % 8 == 0) run_op(s, 2'd3, 1'b0, "R3 random mode3");
    end

    for (int m = 0; m < 4; m++) begin
      s = rand_perm();
      s[63:60] = s[3:0];
      run_op(s, 2'(m), 1'b0, "R7 duplicate");
      check(err == 1'b1 && result == '0, "R7 flag and zero", result, 64'd0);
    end
    s = rand_perm();
    s[35:32] = s[31:28];
    run_op(s, 2'd1, 1'b0, "R7 adjacent duplicate");

    s = rand_perm();
    run_op(s, 2'd0, 1'b1, "R8 inputs changed during run");
    held = result;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      state = {$urandom, $urandom};
      mode  = 2'($urandom);
    end
    @(negedge clk);
    check(done == 1'b1 && result == held, "R8 held after done", result, held);

    // R9: restart mid-run
    s  = rand_perm();
    s2 = rand_perm();
    @(negedge clk);
    state = s; mode = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    run_op(s2, 2'd1, 1'b0, "R9 restart mid-run");

    // R9: restart in the cycle done is high
    check(done == 1'b1, "R9 done before restart", 64'(done), 64'd1);
    run_op(s, 2'd0, 1'b0, "R9 restart while done");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule